// File: doc/BRIEF.md
# Indexed Store Address Sequencer

This block sequences the bus for the three store-accumulator instructions of an 8-bit processor that use indexed addressing. It covers absolute indexed by X, absolute indexed by Y, and indirect (zero-page pointer) indexed by Y. The address bus is 13 bits wide. The upper five address bits come from the low five bits of the high address byte. The block holds its own program counter. It fetches the operand bytes at successive counter values and, for the indirect form, reads the two pointer bytes from page zero. It then forms the effective address by adding the selected index register to the base low byte.

The store is always split into two accesses. The first is a dummy read. Its low byte is already the wrapped sum, but its high byte is still the raw base high byte. The second access is the real write. Its high byte is corrected by the carry out of the low-byte sum. During the write the accumulator is driven on the write-data output and a one-cycle done pulse is raised. The sequencer then returns to opcode fetch with the counter pointing at the next instruction. The extra correction cycle is spent whether or not a page boundary is crossed.

The controller has seven named states:
- FETCH: opcode fetch.
- OPLO: first operand, which is the base low byte or the pointer.
- OPHI: second operand, the base high byte.
- PTRLO: pointer low read.
- PTRHI: pointer high read.
- DUMMY: dummy read.
- WRITE: final write.

The transitions are:
- FETCH goes to OPLO when an accepted opcode is started.
- OPLO goes to OPHI for the absolute forms and to PTRLO for the indirect form.
- OPHI goes to DUMMY.
- PTRLO goes to PTRHI, and PTRHI goes to DUMMY.
- DUMMY goes to WRITE, and WRITE goes to FETCH.

Top module: `idx_store_seq`

## Requirements
- R1: Only opcodes 0x9D (absolute, index X), 0x99 (absolute, index Y) and 0x91 (indirect, index Y) are accepted when `start` is high in FETCH. With any other opcode, `start` is ignored: the state stays FETCH, `addr` stays at the counter and `rw` stays 0.
- R2: In FETCH and in the operand cycles, `addr` equals the program counter and `rw` is 0. The counter advances by one on leaving FETCH and after each operand byte fetch.
- R3: The absolute forms take the base low byte in the first operand cycle and the base high byte in the second. The selected index is X for 0x9D and Y for the other two opcodes; the unselected register has no effect on any address.
- R4: In the DUMMY cycle, `rw` is 0 and `done` is 0. `addr[7:0]` is (base low + index) mod 256 and `addr[12:8]` is base high bits [4:0].
- R5: In the WRITE cycle, `rw` is 1 and `addr[7:0]` is the same wrapped sum. `addr[12:8]` is (base high[4:0] + carry) mod 32, where carry is 1 when base low + index exceeds 255.
- R6: The DUMMY cycle is always followed by the WRITE cycle, even without a page crossing. From the start cycle, the sequence takes 5 cycles for the absolute forms and 6 for the indirect form.
- R7: For 0x91, the first operand byte is a pointer P. The next two cycles read base low at address P and base high at address (P + 1) mod 256, both with `addr[12:8]` = 0.
- R8: In the WRITE cycle, `data_out` equals `acc` and `done` is 1 for exactly that one cycle. In every other cycle, `data_out` is 0.
- R9: After WRITE the block is back in FETCH with the counter equal to the start value + 3 for the absolute forms and + 2 for the indirect form (mod 2^13).
- R10: A synchronous reset, at any point in a sequence, puts the block in FETCH with the counter at `RESET_PC`, `rw` = 0 and `done` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin the instruction whose opcode is on `opcode` (sampled in FETCH) |
| opcode | input | 8 | Opcode of the instruction being started |
| data_in | input | 8 | Read data bus |
| x_val | input | 8 | X index register value |
| y_val | input | 8 | Y index register value |
| acc | input | 8 | Accumulator value to be stored |
| addr | output | 13 | Bus address |
| rw | output | 1 | 1 = write cycle, 0 = read cycle |
| data_out | output | 8 | Write data, accumulator during the write, else 0 |
| done | output | 1 | One-cycle pulse in the final write cycle |

## Verification
The assertions assume that the index registers and the accumulator hold steady from the dummy read through the write. They also assume that `data_in` carries the byte for the current address in the cycle that address is shown. The bench drives each operand or pointer byte at the falling edge in the cycle that requests it. It sets X, Y and the accumulator once per instruction, before the opcode-fetch cycle. It changes `start` and `opcode` only in FETCH. The stimulus covers page crossings, wraparound of the 5-bit high field and a pointer at 0xFF.

// File: rtl/isq_pkg.sv
package isq_pkg;

    localparam int DW = 8;

    typedef enum logic [2:0] {
        S_FETCH,
        S_OPLO,
        S_OPHI,
        S_PTRLO,
        S_PTRHI,
        S_DUMMY,
        S_WRITE
    } state_t;

    typedef enum logic [1:0] {
        M_ABS_X,
        M_ABS_Y,
        M_IND_Y
    } mode_t;

    localparam logic [DW-1:0] OP_ABS_X = 8'h9D;
    localparam logic [DW-1:0] OP_ABS_Y = 8'h99;
    localparam logic [DW-1:0] OP_IND_Y = 8'h91;

    function automatic logic op_known(input logic [DW-1:0] op);
        return (op == OP_ABS_X) || (op == OP_ABS_Y) || (op == OP_IND_Y);
    endfunction

    function automatic mode_t op_mode(input logic [DW-1:0] op);
        mode_t m;
        case (op)
            OP_ABS_X: m = M_ABS_X;
            OP_ABS_Y: m = M_ABS_Y;
            default:  m = M_IND_Y;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/isq_ctrl.sv
module isq_ctrl
    import isq_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DW-1:0]     opcode,
    output state_t            state,
    output mode_t             mode,
    output logic [ADDR_W-1:0] pc,
    output logic              rw,
    output logic              done
);

    state_t state_q, state_d;
    mode_t  mode_q;
    logic [ADDR_W-1:0] pc_q;
    logic accept;

    assign accept = (state_q == S_FETCH) && start && op_known(opcode);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_FETCH;
        else     state_q <= state_d;
    end

    // mode and program counter
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= M_ABS_X;
            pc_q   <= RESET_PC;
        end else begin
            if (accept) mode_q <= op_mode(opcode);
            if (accept || state_q == S_OPLO || state_q == S_OPHI)
                pc_q <= pc_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FETCH: state_d = accept ? S_OPLO : S_FETCH;
            S_OPLO:  state_d = (mode_q == M_IND_Y) ? S_PTRLO : S_OPHI;
            S_OPHI:  state_d = S_DUMMY;
            S_PTRLO: state_d = S_PTRHI;
            S_PTRHI: state_d = S_DUMMY;
            S_DUMMY: state_d = S_WRITE;
            S_WRITE: state_d = S_FETCH;
            default: state_d = S_FETCH;
        endcase
    end

    // outputs
    always_comb begin
        rw   = 1'b0;
        done = 1'b0;
        unique case (state_q)
            S_WRITE: begin
                rw   = 1'b1;
                done = 1'b1;
            end
            default: begin
                rw   = 1'b0;
                done = 1'b0;
            end
        endcase
    end

    assign state = state_q;
    assign mode  = mode_q;
    assign pc    = pc_q;

    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_OPLO) |=> (pc_q == $past(pc_q) + 1'b1));

    p_dummy_write_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_DUMMY) |=> (state_q == S_WRITE));

    p_ignore_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_FETCH && !start) |=> (state_q == S_FETCH && pc_q == $past(pc_q)));

endmodule

// File: rtl/isq_addr.sv
module isq_addr
    import isq_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  state_t            state,
    input  mode_t             mode,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DW-1:0]     data_in,
    input  logic [DW-1:0]     x_val,
    input  logic [DW-1:0]     y_val,
    output logic [ADDR_W-1:0] addr
);

    localparam int HI_W = ADDR_W - DW;

    logic [DW-1:0]   ptr_q, blo_q, sum_q, idx, ptr_nx;
    logic [HI_W-1:0] bhi_q;
    logic            carry_q;
    logic [DW:0]     raw;

    assign idx    = (mode == M_ABS_X) ? x_val : y_val;
    assign raw    = {1'b0, blo_q} + {1'b0, idx};
    assign ptr_nx = ptr_q + 8'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            blo_q   <= '0;
            bhi_q   <= '0;
            sum_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            unique case (state)
                S_OPLO: begin
                    if (mode == M_IND_Y) ptr_q <= data_in;
                    else                 blo_q <= data_in;
                end
                S_OPHI:  bhi_q <= data_in[HI_W-1:0];
                S_PTRLO: blo_q <= data_in;
                S_PTRHI: bhi_q <= data_in[HI_W-1:0];
                S_DUMMY: begin
                    sum_q   <= raw[DW-1:0];
                    carry_q <= raw[DW];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            S_PTRLO: addr = {{HI_W{1'b0}}, ptr_q};
            S_PTRHI: addr = {{HI_W{1'b0}}, ptr_nx};
            S_DUMMY: addr = {bhi_q, raw[DW-1:0]};
            S_WRITE: addr = {bhi_q + HI_W'(carry_q), sum_q};
            default: addr = pc;
        endcase
    end

    p_low_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (state == S_WRITE) |-> (addr[DW-1:0] == $past(addr[DW-1:0])));

    p_high_step_r5: assert property (@(posedge clk) disable iff (rst)
        (state == S_WRITE) |->
            ((addr[ADDR_W-1:DW] == $past(addr[ADDR_W-1:DW])) ||
             (addr[ADDR_W-1:DW] == $past(addr[ADDR_W-1:DW]) + 1'b1)));

    p_ptr_adjacent_r7: assert property (@(posedge clk) disable iff (rst)
        (state == S_PTRHI) |->
            ((addr[DW-1:0] == $past(addr[DW-1:0]) + 8'd1) && (addr[ADDR_W-1:DW] == '0)));

endmodule

// File: rtl/idx_store_seq.sv
module idx_store_seq
    import isq_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [7:0]        data_in,
    input  logic [7:0]        x_val,
    input  logic [7:0]        y_val,
    input  logic [7:0]        acc,
    output logic [ADDR_W-1:0] addr,
    output logic              rw,
    output logic [7:0]        data_out,
    output logic              done
);

    state_t state;
    mode_t  mode;
    logic [ADDR_W-1:0] pc;

    isq_ctrl #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .opcode (opcode),
        .state  (state),
        .mode   (mode),
        .pc     (pc),
        .rw     (rw),
        .done   (done)
    );

    isq_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .mode    (mode),
        .pc      (pc),
        .data_in (data_in),
        .x_val   (x_val),
        .y_val   (y_val),
        .addr    (addr)
    );

    assign data_out = rw ? acc : '0;

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_read_first_r4: assert property (@(posedge clk) disable iff (rst)
        rw |-> !$past(rw));

endmodule

// File: tb/idx_store_seq_test.sv
`timescale 1ns/1ps
module idx_store_seq_test;

    localparam logic [12:0] RST_PC = 13'h0200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0, data_in = '0, x_val = '0, y_val = '0, acc = '0;
    logic [12:0] addr;
    logic        rw, done;
    logic [7:0]  data_out;

    int n_run = 0;
    int n_fail = 0;
    logic [12:0] pc_m;

    always #2 clk = ~clk;

    idx_store_seq #(.ADDR_W(13), .RESET_PC(RST_PC)) uut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .data_in(data_in),
        .x_val(x_val), .y_val(y_val), .acc(acc),
        .addr(addr), .rw(rw), .data_out(data_out), .done(done)
    );

    // {opcode, x, y, acc, operand1, operand2, ptr_lo_byte, ptr_hi_byte}
    localparam logic [63:0] VEC [8] = '{
        {8'h9D, 8'h05, 8'h00, 8'hA1, 8'h10, 8'h03, 8'h00, 8'h00},
        {8'h9D, 8'hF0, 8'h00, 8'h5A, 8'h20, 8'h04, 8'h00, 8'h00},
        {8'h99, 8'h00, 8'h01, 8'h3C, 8'hFF, 8'h1F, 8'h00, 8'h00},
        {8'h99, 8'hFF, 8'h02, 8'hC3, 8'h40, 8'h12, 8'h00, 8'h00},
        {8'h91, 8'h77, 8'h10, 8'h11, 8'h80, 8'h00, 8'h34, 8'h0A},
        {8'h91, 8'h00, 8'hF0, 8'h22, 8'hFF, 8'h00, 8'h20, 8'h07},
        {8'h91, 8'h00, 8'h00, 8'h99, 8'h00, 8'h00, 8'hFF, 8'hE3},
        {8'h9D, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic run_vec(input logic [63:0] v);
        logic [7:0] op, xv, yv, av, b1, b2, plo, phi, idx, bl, bh;
        logic [8:0] sum;
        logic [12:0] dummy_a, final_a, pc0;
        logic ind;
        {op, xv, yv, av, b1, b2, plo, phi} = v;
        ind = (op == 8'h91);
        idx = (op == 8'h9D) ? xv : yv;
        bl  = ind ? plo : b1;
        bh  = ind ? phi : b2;
        sum = {1'b0, bl} + {1'b0, idx};
        dummy_a = {bh[4:0], sum[7:0]};
        final_a = {bh[4:0] + {4'b0, sum[8]}, sum[7:0]};
        pc0 = pc_m;
        x_val = xv; y_val = yv; acc = av;
        opcode = op; start = 1'b1;
        chk("R2 fetch addr", 32'(addr), 32'(pc0));
        chk("R2 fetch rw", 32'(rw), 0);
        @(negedge clk);
        start = 1'b0; opcode = 8'h00;
        chk("R2 first operand addr", 32'(addr), 32'(pc0 + 13'd1));
        chk("R8 data_out idle", 32'(data_out), 0);
        data_in = b1;
        @(negedge clk);
        if (!ind) begin
            chk("R3 second operand addr", 32'(addr), 32'(pc0 + 13'd2));
            chk("R2 operand rw", 32'(rw), 0);
            data_in = b2;
        end else begin
            chk("R7 pointer low addr", 32'(addr), 32'({5'b0, b1}));
            data_in = plo;
            @(negedge clk);
            chk("R7 pointer high addr", 32'(addr), 32'({5'b0, b1 + 8'd1}));
            data_in = phi;
        end
        @(negedge clk);
        data_in = 8'h00;
        chk("R4 dummy addr", 32'(addr), 32'(dummy_a));
        chk("R4 dummy rw", 32'(rw), 0);
        chk("R4 dummy done", 32'(done), 0);
        @(negedge clk);
        chk("R5 write addr", 32'(addr), 32'(final_a));
        chk("R5 write rw", 32'(rw), 1);
        chk("R8 write data", 32'(data_out), 32'(av));
        chk("R8 done", 32'(done), 1);
        @(negedge clk);
        pc_m = pc0 + (ind ? 13'd2 : 13'd3);
        chk("R9 next fetch addr", 32'(addr), 32'(pc_m));
        chk("R6 done single", 32'(done), 0);
        chk("R9 fetch rw", 32'(rw), 0);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        pc_m = RST_PC;
        chk("R10 reset addr", 32'(addr), 32'(RST_PC));
        chk("R10 reset rw", 32'(rw), 0);
        chk("R10 reset done", 32'(done), 0);

        foreach (VEC[i]) run_vec(VEC[i]);

        // R1: unsupported opcodes are ignored
        opcode = 8'hA9; start = 1'b1;
        @(negedge clk);
        chk("R1 ignored opcode addr", 32'(addr), 32'(pc_m));
        chk("R1 ignored opcode rw", 32'(rw), 0);
        opcode = 8'h8D;
        @(negedge clk);
        chk("R1 plain store ignored addr", 32'(addr), 32'(pc_m));
        start = 1'b0;
        @(negedge clk);
        chk("R1 still fetch", 32'(addr), 32'(pc_m));

        // R6: sequence continues after ignored opcodes
        run_vec({8'h99, 8'h00, 8'h80, 8'h6E, 8'h90, 8'h01, 8'h00, 8'h00});

        // R10: reset in the middle of a sequence
        opcode = 8'h9D; start = 1'b1; x_val = 8'h01;
        @(negedge clk);
        start = 1'b0; data_in = 8'h55;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R10 mid reset addr", 32'(addr), 32'(RST_PC));
        chk("R10 mid reset rw", 32'(rw), 0);
        chk("R10 mid reset done", 32'(done), 0);
        rst = 1'b0;
        pc_m = RST_PC;
        @(negedge clk);
        chk("R10 stays in fetch", 32'(addr), 32'(RST_PC));
        run_vec({8'h91, 8'h00, 8'h01, 8'h42, 8'h10, 8'h00, 8'hFF, 8'h1F});

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule